// File: doc/BRIEF.md
# Packed-Lane Saturating Arithmetic Unit

This unit treats each 64-bit operand as a packed group of narrow integers and applies one operation to every group member in parallel. The caller chooses the group layout (eight 8-bit, four 16-bit or two 32-bit lanes), whether lanes are read as signed or unsigned, and one of eight operations. Carries and borrows stop at every lane edge for the chosen layout.

The operations are:

- lane-wise add and subtract that wrap modulo the lane size;
- add and subtract that clamp to the lane's range instead of wrapping;
- lane-wise minimum and maximum;
- a sum of absolute differences, which reduces all lanes to one scalar.

The unit has no state visible to the caller beyond its output register, and it raises no exceptions. A request arrives with a valid strobe. The result and its valid flag are registered, so the unit returns a result exactly one cycle later and can take a new request on every cycle.

Top module: `simd_sat_alu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` in a cycle equals `in_valid` of the cycle before. `result` is loaded only when `in_valid` is 1 and holds its value otherwise.
- R3: `lane_sz` encoding: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 give two 32-bit lanes. Lane k occupies bits [k*W +: W]. No carry or borrow crosses from one lane into the next.
- R4: `op` 0 gives the lane-wise sum modulo 2^W and `op` 1 gives a minus b modulo 2^W. Both ignore `is_signed`.
- R5: `op` 2 is a clamping add. With `is_signed`=1 the result is clamped to [-2^(W-1), 2^(W-1)-1]. With `is_signed`=0 it is clamped to [0, 2^W-1].
- R6: `op` 3 is a clamping subtract a minus b, with the same clamp limits as R5.
- R7: `op` 4 gives the lane-wise minimum and `op` 5 the lane-wise maximum. Lanes are compared as two's complement when `is_signed`=1 and as unsigned otherwise.
- R8: `op` 6 gives the sum over all lanes of |a-b|, with the lanes read as unsigned whatever `is_signed` is. The sum is zero-extended into the low bits of `result`.
- R9: `op` 7 gives an all-zero result.
- R10: Requests on consecutive cycles each produce their own result, one cycle after each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (R4 to R9) |
| lane_sz | input | 2 | Lane layout select (R3) |
| is_signed | input | 1 | Signed lane interpretation |
| a | input | 64 | First packed operand |
| b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered packed result or scalar sum |

## Verification
Every result is due on the first rising edge after its request is driven, and `out_valid` follows on that same edge. The bench drives each request on a falling edge and checks the previous request's expected value on the next falling edge, half a cycle after the capturing edge. Idle cycles are checked at the same point, for a low `out_valid` and a `result` unchanged from the last one loaded. Back-to-back requests therefore each meet their own expected value without overlap.

// File: rtl/simd_sat_alu.sv
module simd_sat_alu #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        lane_sz,
  input  logic              is_signed,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  localparam int NSZ = 3;
  localparam logic [2:0] OP_ADDW = 3'd0;
  localparam logic [2:0] OP_SUBW = 3'd1;
  localparam logic [2:0] OP_ADDS = 3'd2;
  localparam logic [2:0] OP_SUBS = 3'd3;
  localparam logic [2:0] OP_MIN  = 3'd4;
  localparam logic [2:0] OP_MAX  = 3'd5;
  localparam logic [2:0] OP_SAD  = 3'd6;

  logic [WORD_W-1:0] sz_res [NSZ];
  logic [1:0]        sz_idx;
  logic [WORD_W-1:0] nxt;

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int LW = 8 << g;
    localparam int NL = WORD_W / LW;
    localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
    logic [WORD_W-1:0] res_v;
    logic [WORD_W-1:0] ad_v;
    logic [WORD_W-1:0] sad;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [LW-1:0] x, y, r;
      logic [LW:0]   s, d;
      logic          sov, dov, lt;
      assign x   = a[l*LW +: LW];
      assign y   = b[l*LW +: LW];
      assign s   = {1'b0, x} + {1'b0, y};
      assign d   = {1'b0, x} - {1'b0, y};
      assign sov = (x[LW-1] == y[LW-1]) && (s[LW-1] != x[LW-1]);
      assign dov = (x[LW-1] != y[LW-1]) && (d[LW-1] != x[LW-1]);
      assign lt  = is_signed ? ($signed(x) < $signed(y)) : (x < y);

      always_comb begin
        case (op)
          OP_ADDW: r = s[LW-1:0];
          OP_SUBW: r = d[LW-1:0];
          OP_ADDS:
            if (is_signed) r = sov ? (x[LW-1] ? SMIN : SMAX) : s[LW-1:0];
            else           r = s[LW] ? '1 : s[LW-1:0];
          OP_SUBS:
            if (is_signed) r = dov ? (x[LW-1] ? SMIN : SMAX) : d[LW-1:0];
            else           r = d[LW] ? '0 : d[LW-1:0];
          OP_MIN:  r = lt ? x : y;
          OP_MAX:  r = lt ? y : x;
          default: r = '0;
        endcase
      end

      assign res_v[l*LW +: LW] = r;
      assign ad_v[l*LW +: LW]  = d[LW] ? (y - x) : d[LW-1:0];
    end

    always_comb begin
      sad = '0;
      for (int l = 0; l < NL; l++)
        sad = sad + {{(WORD_W-LW){1'b0}}, ad_v[l*LW +: LW]};
    end

    assign sz_res[g] = (op == OP_SAD) ? sad : res_v;
  end

  assign sz_idx = (lane_sz == 2'd0) ? 2'd0 : (lane_sz == 2'd1) ? 2'd1 : 2'd2;
  assign nxt    = sz_res[sz_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [1:0]  lane_sz,
  input logic        is_signed,
  input logic [63:0] a,
  input logic [63:0] b,
  input logic        out_valid,
  input logic [63:0] result
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == 64'd0));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2 && lane_sz == 2'd0 && !is_signed)
      |=> result[7:0] >= $past(a[7:0]));

  assert_min_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4 && lane_sz == 2'd2 && !is_signed)
      |=> ((result[31:0] == $past(a[31:0]) || result[31:0] == $past(b[31:0]))
           && result[31:0] <= $past(a[31:0]) && result[31:0] <= $past(b[31:0])));

  assert_sad_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd6 && lane_sz == 2'd0) |=> result[63:11] == 53'd0);

  assert_zero_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> result == 64'd0);
endmodule

bind simd_sat_alu simd_sat_alu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
  .is_signed(is_signed), .a(a), .b(b), .out_valid(out_valid), .result(result)
);

// File: tb/simd_sat_alu_tb.sv
module simd_sat_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  lane_sz = '0;
  logic        is_signed = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;
  logic        pv = 1'b0;
  logic [63:0] pexp = '0;
  logic [63:0] last_res = '0;
  string       ptag = "R2";
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sat_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .is_signed(is_signed), .a(a), .b(b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_model(logic [2:0] o, logic [1:0] sz, logic sg,
                                            logic [63:0] x, logic [63:0] y);
    int lw = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    longint m = (longint'(1) << lw) - 1;
    longint half = longint'(1) << (lw - 1);
    longint lo = sg ? -half : 0;
    longint hi = sg ? half - 1 : m;
    longint sad = 0;
    logic [63:0] out = '0;
    for (int l = 0; l < 64 / lw; l++) begin
      longint ua = longint'((x >> (l * lw)) & 64'(m));
      longint ub = longint'((y >> (l * lw)) & 64'(m));
      longint xa = (sg && ua >= half) ? ua - (m + 1) : ua;
      longint xb = (sg && ub >= half) ? ub - (m + 1) : ub;
      longint r;
      case (o)
        3'd0: r = ua + ub;
        3'd1: r = ua - ub;
        3'd2: begin r = xa + xb; if (r > hi) r = hi; if (r < lo) r = lo; end
        3'd3: begin r = xa - xb; if (r > hi) r = hi; if (r < lo) r = lo; end
        3'd4: r = (xa < xb) ? xa : xb;
        3'd5: r = (xa < xb) ? xb : xa;
        default: r = 0;
      endcase
      sad += (ua > ub) ? ua - ub : ub - ua;
      out = out | ((64'(r) & 64'(m)) << (l * lw));
    end
    if (o == 3'd6) out = 64'(sad);
    return out;
  endfunction

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R4";
      3'd2:       return "R5";
      3'd3:       return "R6";
      3'd4, 3'd5: return "R7";
      3'd6:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic check_prev();
    checks++;
    if (out_valid !== pv) begin
      fails++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, pv);
    end
    if (pv) begin
      checks++;
      if (result !== pexp) begin
        fails++;
        $display("FAIL %s result actual=%h expected=%h", ptag, result, pexp);
      end
      last_res = pexp;
    end else begin
      checks++;
      if (result !== last_res) begin
        fails++;
        $display("FAIL R2 idle hold actual=%h expected=%h", result, last_res);
      end
    end
  endtask

  task automatic step(logic v, logic [2:0] o, logic [1:0] sz, logic sg,
                      logic [63:0] x, logic [63:0] y, string tag);
    @(negedge clk);
    check_prev();
    in_valid = v; op = o; lane_sz = sz; is_signed = sg; a = x; b = y;
    pv = v;
    if (v) pexp = ref_model(o, sz, sg, x, y);
    ptag = (tag == "") ? req_of(o) : tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      fails++;
      $display("FAIL R1 reset actual=%0b/%h expected=0/0", out_valid, result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      fails++;
      $display("FAIL R1 after reset actual=%0b/%h expected=0/0", out_valid, result);
    end

    step(1, 3'd2, 2'd0, 0, 64'h00000000_000000FF, 64'h01, "R5");
    step(1, 3'd2, 2'd0, 1, 64'h7F, 64'h01, "R5");
    step(1, 3'd3, 2'd0, 1, 64'h80, 64'h01, "R6");
    step(1, 3'd3, 2'd1, 0, 64'h0000, 64'h0001, "R6");
    step(1, 3'd0, 2'd1, 0, 64'h0000_0000_0000_FFFF, 64'h1, "R3");
    step(1, 3'd1, 2'd0, 0, 64'h0000_0000_0000_0100, 64'h1, "R3");
    step(1, 3'd0, 2'd3, 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, "R3");
    step(1, 3'd6, 2'd2, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R8");
    step(1, 3'd6, 2'd0, 1, 64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, "R8");
    step(1, 3'd4, 2'd0, 1, 64'h80, 64'h7F, "R7");
    step(1, 3'd5, 2'd1, 0, 64'h8000, 64'h7FFF, "R7");
    step(1, 3'd7, 2'd0, 0, 64'hFFFF, 64'h1234, "R9");
    step(0, 3'd0, 2'd0, 0, 64'hDEAD, 64'hBEEF, "R2");
    step(1, 3'd0, 2'd0, 0, 64'h0101, 64'h0202, "R10");
    step(1, 3'd1, 2'd0, 0, 64'h0505, 64'h0101, "R10");

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] x = {$urandom, $urandom};
      logic [63:0] y = {$urandom, $urandom};
      if (($urandom % 4) == 0) begin
        x[7:0] = 8'h7F;
        y[7:0] = 8'h80 | 8'($urandom % 2);
      end
      step(($urandom % 5) != 0, 3'($urandom), 2'($urandom), 1'($urandom), x, y, "");
    end
    step(0, 3'd0, 2'd0, 0, 64'h0, 64'h0, "R2");
    @(negedge clk);
    check_prev();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule